// File: doc/BRIEF.md
# Carry-Select Adder Built From 8-Bit Lookahead Segments

This block adds two W-bit operands and a carry-in and returns a W-bit sum with a carry-out, purely combinationally. The operand width is cut into 8-bit segments. Inside every segment, all eight carries come from fully expanded generate/propagate sums of products, so no carry ripples from bit to bit within a segment.

The lowest segment is built once and takes the external carry-in. Every higher segment is built twice: one copy assumes an incoming carry of 0 and the other assumes 1. Both copies settle in parallel. A 2:1 selector then forwards one copy's sum and carry-out, chosen by the carry that leaves the stage below. The only serial path across the adder is therefore the chain of selectors, one per segment.

The block fits anywhere a wide single-cycle add is needed, such as the final carry-propagate step of a multiplier. W is a parameter and must be a whole multiple of 8.

Top module: `csel_adder`

## Requirements
- R1: {cout, sum} equals the (W+1)-bit value a + b + cin for every operand pair and carry-in.
- R2: Each 8-bit segment returns the 9-bit result seg_a + seg_b + seg_cin, with its internal carries formed as flattened lookahead products and no rippling.
- R3: Each sum bit k equals a[k] XOR b[k] XOR the carry into position k. For example, a=0x0F and b=0xF0 with cin=0 give 0xFF and no carry-out.
- R4: The lowest segment uses the external cin directly. With a=0, b=0 and cin=1, the sum is 1 and cout is 0.
- R5: For every higher segment, the copy built with carry-in 1 is chosen when the carry leaving the stage below is 1, and the copy built with carry-in 0 is chosen otherwise. For example, a=0xFF, b=0x01, cin=0 gives a sum of 0x100.
- R6: A carry travels through every segment. An all-ones operand plus zero with cin=1 gives a sum of zero and cout=1.
- R7: cout is the selected carry-out of the top segment. For example, a = b = 2^(W-1) gives cout=1 and a sum of zero.
- R8: W must be a positive multiple of 8. Any other value stops elaboration.
- R9: When no bit position generates a carry and cin=0, cout is 0. For example, a + ~a with cin=0 gives all ones and cout=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry into the lowest segment |
| sum | output | W | Sum bits |
| cout | output | 1 | Carry out of the top segment |

## Verification
The embedded assertions check three relations whenever the inputs change:
- every segment's 9-bit result matches a plain addition;
- within each duplicated pair, the carry-in-1 copy's sum is exactly one above the carry-in-0 copy's, and its carry-out is never lower;
- the full result matches a + b + cin, and cout follows cin whenever every bit position only propagates.

Only the directed scenarios can show that particular carry paths are really taken: the first segment absorbing cin, a carry crossing one segment boundary, a carry running the full width, a carry-out from the top bit alone, and a case with no carry at all.

// File: rtl/csel_pkg.sv
package csel_pkg;
   // Width of one lookahead segment; the select chain is built around it.
   localparam int unsigned SEG_W = 8;
   typedef logic [SEG_W-1:0] seg_word_t;
endpackage

// File: rtl/csel_cla_seg.sv
module csel_cla_seg
   import csel_pkg::*;
(
   input  logic [SEG_W-1:0] a,
   input  logic [SEG_W-1:0] b,
   input  logic             cin,
   output logic [SEG_W-1:0] sum,
   output logic             cout
);
   logic [SEG_W-1:0] gen;
   logic [SEG_W-1:0] prp;
   logic [SEG_W:0]   cy;

   assign gen = a & b;
   assign prp = a ^ b;

   // Each carry is an OR of product terms over the generate and propagate bits
   // below it plus cin (R2): no carry is taken from the previous position.
   always_comb begin
      cy[0] = cin;
      for (int k = 0; k < SEG_W; k++) begin
         logic acc;
         logic prod;
         acc = 1'b0;
         for (int j = 0; j <= k; j++) begin
            prod = gen[j];
            for (int m = j + 1; m <= k; m++) prod = prod & prp[m];
            acc = acc | prod;
         end
         prod = cin;
         for (int m = 0; m <= k; m++) prod = prod & prp[m];
         cy[k+1] = acc | prod;
      end
   end

   // R3: sum bit is the propagate term XOR the carry into that position
   assign sum  = prp ^ cy[SEG_W-1:0];
   assign cout = cy[SEG_W];

   always_comb begin
      assert_seg_sum_R2: assert ({cout, sum} ==
                                 ({1'b0, a} + {1'b0, b} + {{SEG_W{1'b0}}, cin}))
         else $error("segment result differs from arithmetic sum");
   end
endmodule

// File: rtl/csel_pair.sv
module csel_pair
   import csel_pkg::*;
(
   input  logic [SEG_W-1:0] a,
   input  logic [SEG_W-1:0] b,
   input  logic             sel,
   output logic [SEG_W-1:0] sum,
   output logic             cout
);
   seg_word_t sum_lo, sum_hi;
   logic      cout_lo, cout_hi;

   csel_cla_seg u_assume0 (.a(a), .b(b), .cin(1'b0), .sum(sum_lo), .cout(cout_lo));
   csel_cla_seg u_assume1 (.a(a), .b(b), .cin(1'b1), .sum(sum_hi), .cout(cout_hi));

   // R5: the incoming carry picks which precomputed copy is forwarded
   always_comb begin
      if (sel) begin
         sum  = sum_hi;
         cout = cout_hi;
      end else begin
         sum  = sum_lo;
         cout = cout_lo;
      end
   end

   always_comb begin
      assert_pair_step_R5: assert (sum_hi == seg_word_t'(sum_lo + 1'b1))
         else $error("carry-in-1 copy is not one above carry-in-0 copy");
      assert_pair_carry_order_R5: assert (!(cout_lo && !cout_hi))
         else $error("carry-in-1 copy lost a carry the other copy produced");
   end
endmodule

// File: rtl/csel_adder.sv
module csel_adder
   import csel_pkg::*;
#(
   parameter int unsigned W = 64
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   localparam int unsigned NSEG = W / SEG_W;

   // R8: width must divide evenly into segments
   if ((W % SEG_W) != 0 || W == 0) begin : g_bad_width
      $error("csel_adder: W must be a positive multiple of segment width");
   end

   logic [NSEG:0] chain;
   assign chain[0] = cin;

   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      if (s == 0) begin : g_first
         // R4: lowest segment, single copy fed by the external carry
         csel_cla_seg u_seg (
            .a    (a[SEG_W-1:0]),
            .b    (b[SEG_W-1:0]),
            .cin  (chain[0]),
            .sum  (sum[SEG_W-1:0]),
            .cout (chain[1])
         );
      end else begin : g_dup
         csel_pair u_pair (
            .a    (a[s*SEG_W +: SEG_W]),
            .b    (b[s*SEG_W +: SEG_W]),
            .sel  (chain[s]),
            .sum  (sum[s*SEG_W +: SEG_W]),
            .cout (chain[s+1])
         );
      end
   end

   // R7: final selected carry leaves the block
   assign cout = chain[NSEG];

   always_comb begin
      assert_total_R1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
         else $error("adder result differs from a+b+cin");
      assert_all_prop_R6: assert (!((a ^ b) == {W{1'b1}}) || (cout == cin && (sum == {W{~cin}})))
         else $error("pure propagate pattern did not pass cin through");
   end
endmodule

// File: tb/tb_csel_adder.sv
module tb_csel_adder;
   localparam int unsigned W = 64;

   logic         clk = 1'b0;
   logic [W-1:0] a   = '0;
   logic [W-1:0] b   = '0;
   logic         cin = 1'b0;
   logic [W-1:0] sum;
   logic         cout;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   csel_adder #(.W(W)) dut (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

   task automatic apply_check(input string req, input logic [W-1:0] va,
                              input logic [W-1:0] vb, input logic vc);
      logic [W:0] expv;
      @(negedge clk);
      a = va; b = vb; cin = vc;
      expv = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
      @(posedge clk);
      #1;
      checks++;
      if ({cout, sum} !== expv) begin
         fails++;
         $display("FAIL %s: a=%h b=%h cin=%0d got %h expected %h",
                  req, va, vb, vc, {cout, sum}, expv);
      end
   endtask

   function automatic logic [W-1:0] rnd_word();
      logic [W-1:0] v;
      for (int i = 0; i < W; i += 32) v[i +: 32] = $urandom;
      return v;
   endfunction

   task automatic t_idle();      // R1: quiet inputs give zero
      apply_check("R1 zero", '0, '0, 1'b0);
   endtask

   task automatic t_first_cin(); // R4
      apply_check("R4 cin only", '0, '0, 1'b1);
      apply_check("R4 low carry", W'(8'hFE), '0, 1'b1);
   endtask

   task automatic t_bitwise();   // R3
      apply_check("R3 disjoint bits", W'(8'h0F), W'(8'hF0), 1'b0);
      apply_check("R3 alternating", {(W/2){2'b10}}, {(W/2){2'b01}}, 1'b0);
   endtask

   task automatic t_boundary();  // R5, R2
      apply_check("R5 cross one boundary", W'(8'hFF), W'(1), 1'b0);
      for (int s = 1; s < W/8; s++)
         apply_check("R5 per segment carry", W'(8'hFF) << (8*(s-1)),
                     W'(8'h01) << (8*(s-1)), 1'b0);
      apply_check("R2 segment generate chain", W'(16'h80FF), W'(16'h8001), 1'b1);
   endtask

   task automatic t_full_chain(); // R6
      apply_check("R6 all ones plus cin", {W{1'b1}}, '0, 1'b1);
      apply_check("R6 all ones plus all ones", {W{1'b1}}, {W{1'b1}}, 1'b1);
   endtask

   task automatic t_top_carry();  // R7
      apply_check("R7 top bits", {1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}}, 1'b0);
   endtask

   task automatic t_no_carry();   // R9
      logic [W-1:0] v;
      v = rnd_word();
      apply_check("R9 complement pair", v, ~v, 1'b0);
   endtask

   task automatic t_random();     // R1
      for (int n = 0; n < 200; n++)
         apply_check("R1 random", rnd_word(), rnd_word(), 1'($urandom));
   endtask

   initial begin
      #1000000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      t_idle();
      t_first_cin();
      t_bitwise();
      t_boundary();
      t_full_chain();
      t_top_carry();
      t_no_carry();
      t_random();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule